// File: doc/BRIEF.md
# Paged Write Collector with Timed Commit

This block sits between a serial-bus protocol engine and a byte-wide nonvolatile array. While a write transaction is open, the protocol engine passes each received data byte to it with a strobe. The first byte of the transaction also carries the full word address. The block keeps the bytes in a page-sized staging buffer. It also keeps the byte position inside the page, and that position wraps within the page rather than moving on to the next page.

When the transaction closes with a STOP, the block commits the staged bytes to the array. The commit runs inside a self-timed busy window of fixed length. During that window the block holds `busy_o` high. The protocol engine uses this signal to refuse acknowledges, so a host can poll with address bytes until the device answers again. A hardware protect input, sampled at STOP, throws the staged bytes away so that the array is never touched. A transaction that carried no data bytes does nothing at all.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low.
- R2: The byte address is taken from the first strobe of a transaction. The upper bits (`byte_addr_i[13:6]`) select the page row, and the lower six bits select the starting offset. Each later strobe goes to the next offset, and the address presented with it is ignored.
- R3: After offset 63, the next byte goes to offset 0 of the same page row.
- R4: When more than 64 bytes arrive in one transaction, a later byte replaces the earlier byte held at the same offset. Each offset is written to the array at most once, with the latest value.
- R5: Only offsets that received a byte are written. In the k-th cycle of the busy window (k counted from 0), offset k is written if it was received. The array address is `{row, k}` and the data is the buffered byte.
- R6: A STOP that is sampled while idle, with `wp_i` low and at least one byte buffered, raises `busy_o` in the next cycle. `busy_o` then stays high for exactly BUSY_CYCLES cycles.
- R7: While `busy_o` is high, byte strobes and STOP are ignored. After the window ends, no buffered byte from that time exists.
- R8: If `wp_i` is high when STOP is sampled, there is no array write and no busy window, and the buffered bytes are discarded.
- R9: A STOP that closes a transaction with no data bytes starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr_i | input | 14 | Word address; used only with the first byte of a transaction |
| byte_data_i | input | 8 | Received data byte |
| stop_i | input | 1 | One-cycle STOP indication from the protocol engine |
| wp_i | input | 1 | Hardware write protect, high protects the whole array |
| busy_o | output | 1 | Commit window active; protocol engine must not acknowledge |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 14 | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The bench goes after several corner cases, and each one shows a specific fault:

- **Wrap from offset 63 to 0.** A design that carries the offset into the row bits would write to the next page.
- **A 70-byte burst.** A design without overwrite would emit duplicate or stale bytes.
- **Later strobes carrying unrelated addresses.** A design that trusts them would scatter the bytes.
- **Protect high at STOP.** A leaky design would write the array or go busy.
- **An empty transaction.** A design that does not check for data would go busy.
- **Strobes and STOP during the busy window.** If these are not ignored, a later bare STOP starts a second commit.

The busy length is counted exactly, and every write is compared with a scoreboard entry in ascending offset order.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    // Width of a counter that must represent values 0 .. n-1.
    function automatic int unsigned pgw_cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/pgw_offset.sv
module pgw_offset #(
    parameter int unsigned OFF_W = 6,
    parameter int unsigned ROW_W = 8,
    localparam int unsigned ADDR_W = OFF_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              end_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_txn_o,
    output logic [OFF_W-1:0]  tgt_off_o,
    output logic [ROW_W-1:0]  row_o
);
    typedef struct packed {
        logic             in_txn;
        logic [ROW_W-1:0] row;
        logic [OFF_W-1:0] off;
    } ofs_st_t;

    ofs_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        tgt_off_o = st_q.in_txn ? st_q.off : addr_i[OFF_W-1:0];
        if (acc_i) begin
            st_d.in_txn = 1'b1;
            if (!st_q.in_txn) st_d.row = addr_i[ADDR_W-1:OFF_W];
            st_d.off = tgt_off_o + OFF_W'(1);   // wraps inside the page
        end
        if (end_i) st_d.in_txn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_txn_o = st_q.in_txn;
    assign row_o    = st_q.row;

    // R3: offset wraps to 0 without disturbing the page row
    p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !end_i && st_q.in_txn && st_q.off == '1)
            |=> (st_q.off == '0 && $stable(st_q.row)));
endmodule

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned OFF_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             clr_i,
    input  logic             hold_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output logic             rd_vld_o,
    output logic [DW-1:0]    rd_data_o
);
    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][DW-1:0] mem;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.mem[wr_off_i] = wr_data_i;
            st_d.vld[wr_off_i] = 1'b1;
        end
        if (clr_i) st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_vld_o  = st_q.vld[rd_off_i];
    assign rd_data_o = st_q.mem[rd_off_i];

    // R7: staged contents frozen during the commit window
    p_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> ($stable(st_q.vld) && $stable(st_q.mem)));
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int unsigned BUSY_CYCLES = 200,
    localparam int unsigned CNT_W = pgw_pkg::pgw_cnt_w(BUSY_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == LAST);
    assign cnt_o  = st_q.cnt;

    // R6: the window closes right after its last cycle and not earlier
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
    parameter int unsigned PAGE_BYTES  = 64,
    parameter int unsigned PAGE_COUNT  = 256,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BUSY_CYCLES = 200,   // must exceed PAGE_BYTES
    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES),
    localparam int unsigned ROW_W  = $clog2(PAGE_COUNT),
    localparam int unsigned ADDR_W = OFF_W + ROW_W,
    localparam int unsigned CNT_W  = pgw_pkg::pgw_cnt_w(BUSY_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [ADDR_W-1:0] byte_addr_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);
    logic             accept, txn_end, commit_go, buf_clr;
    logic             in_txn, done, rd_vld;
    logic [OFF_W-1:0] tgt_off, rd_off;
    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        accept    = byte_vld_i && !busy_o;
        txn_end   = stop_i && !busy_o;
        commit_go = txn_end && in_txn && !wp_i;
        buf_clr   = (txn_end && !commit_go) || done;
        rd_off    = cnt[OFF_W-1:0];
        arr_we_o  = busy_o && (cnt < CNT_W'(PAGE_BYTES)) && rd_vld;
        arr_addr_o = {row, rd_off};
    end

    pgw_offset #(.OFF_W(OFF_W), .ROW_W(ROW_W)) u_offset (
        .clk(clk), .rst_n(rst_n), .acc_i(accept), .end_i(txn_end),
        .addr_i(byte_addr_i), .in_txn_o(in_txn), .tgt_off_o(tgt_off), .row_o(row)
    );

    pgw_buffer #(.DEPTH(PAGE_BYTES), .DW(DATA_W)) u_buffer (
        .clk(clk), .rst_n(rst_n), .wr_i(accept), .wr_off_i(tgt_off),
        .wr_data_i(byte_data_i), .clr_i(buf_clr), .hold_i(busy_o),
        .rd_off_i(rd_off), .rd_vld_o(rd_vld), .rd_data_o(arr_data_o)
    );

    pgw_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit_go),
        .busy_o(busy_o), .done_o(done), .cnt_o(cnt)
    );

    // R6: a window only opens after an unprotected STOP
    p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i)));
    // R8: protected STOP never opens a window
    p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i && !busy_o) |=> !busy_o);
    // R9: STOP with nothing received never opens a window
    p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !in_txn) |=> !busy_o);
endmodule

// File: tb/pgw_ctrl_bench.sv
`timescale 1ns/1ps
module pgw_ctrl_bench;
    localparam int PAGE = 64;
    localparam int BUSY = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [13:0] byte_addr_i = '0;
    logic [7:0]  byte_data_i = '0;
    logic        stop_i = 1'b0;
    logic        wp_i = 1'b0;
    logic        busy_o, arr_we_o;
    logic [13:0] arr_addr_o;
    logic [7:0]  arr_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    logic [21:0] exp_q[$];
    logic [7:0]  m_mem[PAGE];
    bit          m_vld[PAGE];
    logic [7:0]  m_row;
    logic [5:0]  m_off;
    bit          m_in;

    pgw_ctrl #(.BUSY_CYCLES(BUSY)) u_pgw_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .byte_addr_i(byte_addr_i),
        .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o),
        .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every array write must match the next expected item (R5)
    always @(negedge clk) begin
        if (rst_n && arr_we_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", int'({arr_addr_o, arr_data_o}), 0);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check({arr_addr_o, arr_data_o} == e, "R5 write", int'({arr_addr_o, arr_data_o}), int'(e));
            end
        end
    end

    task automatic model_clear();
        for (int i = 0; i < PAGE; i++) m_vld[i] = 0;
        m_in = 0;
    endtask

    task automatic put_byte(input logic [13:0] a, input logic [7:0] d, input bit model);
        byte_vld_i = 1; byte_addr_i = a; byte_data_i = d;
        @(negedge clk);
        byte_vld_i = 0;
        if (model) begin
            if (!m_in) begin m_row = a[13:6]; m_off = a[5:0]; m_in = 1; end
            m_mem[m_off] = d; m_vld[m_off] = 1;
            m_off = m_off + 6'd1;
        end
    endtask

    task automatic close_txn(input logic wp, input bit commit, input string req);
        int n;
        if (commit)
            for (int i = 0; i < PAGE; i++)
                if (m_vld[i]) exp_q.push_back({m_row, 6'(i), m_mem[i]});
        wp_i = wp; stop_i = 1;
        @(negedge clk);
        stop_i = 0; wp_i = 0;
        check(busy_o == commit, req, int'(busy_o), int'(commit));
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        if (commit) check(n == BUSY, "R6 busy length", n, BUSY);
        check(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
        model_clear();
    endtask

    task automatic quiet(input int cycles, input string req);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy_o || arr_we_o) seen = 1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 0, "R1 busy", int'(busy_o), 0);
        check(arr_we_o == 0, "R1 we", int'(arr_we_o), 0);
        rst_n = 1;
        @(negedge clk);
        check(busy_o == 0 && arr_we_o == 0, "R1 after release", int'({busy_o, arr_we_o}), 0);

        // R5/R6: single byte write
        put_byte(14'h1234, 8'hA5, 1);
        close_txn(0, 1, "R6 single byte busy");

        // R2/R3: start at offset 62, later strobes carry junk addresses
        put_byte({8'h3C, 6'd62}, 8'h11, 1);
        put_byte(14'h3FFF, 8'h22, 1);
        put_byte(14'h0000, 8'h33, 1);
        put_byte(14'h1555, 8'h44, 1);
        put_byte(14'h2AAA, 8'h55, 1);
        close_txn(0, 1, "R3 wrap busy");

        // R4: 70 bytes from offset 10 overwrite the first six
        for (int i = 0; i < 70; i++) put_byte({8'hC1, 6'd10}, 8'(i + 8'h40), 1);
        close_txn(0, 1, "R4 overrun busy");

        // R8: protect high discards and blocks
        put_byte(14'h0101, 8'h77, 1);
        put_byte(14'h0101, 8'h78, 1);
        close_txn(1, 0, "R8 protected stop");
        quiet(10, "R8 no activity");
        close_txn(0, 0, "R8 buffer discarded");

        // R9: empty transaction
        close_txn(0, 0, "R9 empty stop");
        quiet(10, "R9 no activity");

        // R7: strobes and STOP during busy are ignored
        put_byte(14'h2040, 8'h99, 1);
        for (int i = 0; i < PAGE; i++)
            if (m_vld[i]) exp_q.push_back({m_row, 6'(i), m_mem[i]});
        stop_i = 1; @(negedge clk); stop_i = 0;
        check(busy_o == 1, "R7 window open", int'(busy_o), 1);
        @(negedge clk);
        put_byte(14'h0500, 8'hE1, 0);
        put_byte(14'h0501, 8'hE2, 0);
        stop_i = 1; @(negedge clk); stop_i = 0;
        while (busy_o) @(negedge clk);
        check(exp_q.size() == 0, "R7 only first commit", exp_q.size(), 0);
        model_clear();
        close_txn(0, 0, "R7 busy-time bytes dropped");
        quiet(10, "R7 no second commit");

        // R2: a fresh transaction after all of the above uses its own address
        put_byte(14'h3FC0, 8'h5A, 1);
        put_byte(14'h0000, 8'h5B, 1);
        close_txn(0, 1, "R2 fresh row");

        summary();
    end
endmodule